// File: doc/BRIEF.md
# Pipelined Burst SRAM with Zero Bus Turnaround

This block is a synchronous single-port memory of 36-bit words, split into four 9-bit lanes. Every input is captured on the rising clock edge. Read data leaves through an output register. Each write takes its data and lane enables two edges after its command. A read also delivers its data two edges after its command. Because the two latencies match, reads and writes can be issued in any mix on every cycle, and the shared data path never needs an idle cycle.

A command is either loaded or advanced. A load starts a read, a write or a deselect, chosen by the select inputs and the write strobe. An advance repeats the last loaded operation at the next burst address. An internal two-bit counter produces that address, in linear or interleaved order. The word count is a parameter. The full organisation is 524288 words, and a small depth keeps simulation cheap.

If a read targets a word whose write data has not yet reached the array, the block forwards that data lane by lane. A read therefore never returns stale contents.

Top module: `pipe_burst_sram`

## Requirements
- R1: While `rst_n` is low, and after its release until the first read completes, `rdata_vld` stays low.
- R2: A read command sampled on edge n drives `rdata` and raises `rdata_vld` right after edge n+2. For write and deselect commands, `rdata_vld` is low at that same point.
- R3: For a write command sampled on edge n, `wdata` and `lane_wr_n` are sampled on edge n+2. Their values at every other edge have no effect on that write.
- R4: Lane i is bits [9i+8:9i]. It is written only when `lane_wr_n[i]` is 0 at the data edge. A lane whose enable is 1 keeps its stored value.
- R5: A load selects the block only when `sel_n` is 0, `sel_a` equals `sel_a_hi` and `sel_b` equals `sel_b_hi`. Any other load is a deselect.
- R6: A load (`burst_go` = 0) on a selected cycle starts a write when `wr_n` is 0 and a read when `wr_n` is 1, at `addr`.
- R7: An advance (`burst_go` = 1) repeats the last loaded operation. It ignores `addr`, `wr_n` and the select inputs, and keeps the upper address bits of the last load.
- R8: With `order_linear` = 1, the k-th advance after a load uses low address bits (start + k) mod 4.
- R9: With `order_linear` = 0, the k-th advance after a load uses low address bits start XOR (k mod 4).
- R10: Reads and writes to different addresses may alternate on consecutive cycles, and each returns or stores the correct data.
- R11: A read issued one or two cycles after a write to the same word returns the newly written lanes merged with the old contents of the untouched lanes.
- R12: A deselect and every advance that follows it leave the memory unchanged and produce no read data.
- R13: After four advances, the burst address wraps back to the loaded start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, taken on a load |
| burst_go | input | 1 | 0 = load a new command, 1 = advance the burst |
| wr_n | input | 1 | 0 = write, 1 = read, taken on a load |
| sel_n | input | 1 | Active-low select |
| sel_a | input | 1 | Select with programmable polarity |
| sel_b | input | 1 | Select with programmable polarity |
| sel_a_hi | input | 1 | Active level of `sel_a` (static) |
| sel_b_hi | input | 1 | Active level of `sel_b` (static) |
| order_linear | input | 1 | Burst order: 1 = linear, 0 = interleaved (static) |
| lane_wr_n | input | LANES | Active-low lane write enables, taken with write data |
| wdata | input | DW | Write data, taken two edges after the write command |
| rdata | output | DW | Registered read data |
| rdata_vld | output | 1 | High when `rdata` carries a read result |

## Verification
The property on linear burst steps assumes that `order_linear` does not change between a load and the advances that follow it. The stimulus changes the burst order only on a cycle that issues a deselect load, which restarts the counter. The deselect property assumes that `sel_n` is a known level on every load. The bench also holds the polarity inputs steady across each command sequence. The latency properties make no assumption about inputs, and the bench feeds deliberately random values on `wdata`, `lane_wr_n`, and the ignored controls of advance cycles, so those two-edge alignments are actually tested.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the pipelined burst SRAM.
// Holds the command encoding and the burst address step rule.
package pbs_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    // Low two address bits for burst step 'step' from start 'start'
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       linear);
        logic [1:0] sum;
        sum = start + step;
        return linear ? sum : (start ^ step);
    endfunction

endpackage

// File: rtl/pbs_cmd_ctrl.sv
`timescale 1ns/1ps
// Command stage: samples the control inputs on each edge and turns them
// into one registered command (operation + word address).
// On a load it latches the start address and the operation. On an advance
// it reuses the latched operation and steps a two-bit burst counter.
// Assumes AW >= 3 and a static burst order within one burst.
module pbs_cmd_ctrl
    import pbs_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_go,
    input  logic          wr_n,
    input  logic          sel_n,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic          sel_a_hi,
    input  logic          sel_b_hi,
    input  logic          order_linear,
    input  logic [AW-1:0] addr,
    output op_e           cmd_op,
    output logic [AW-1:0] cmd_addr
);

    logic [AW-1:0] base_q;
    logic [1:0]    step_q;
    logic [1:0]    step_inc;
    logic          selected;

    // Block selection from the three select inputs and their polarities
    always_comb selected = !sel_n && (sel_a == sel_a_hi) && (sel_b == sel_b_hi);

    // Next burst step
    always_comb step_inc = step_q + 2'd1;

    // Load or advance the command register and the burst state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            step_q   <= 2'd0;
            cmd_op   <= OP_NOP;
            cmd_addr <= '0;
        end else if (!burst_go) begin
            base_q   <= addr;
            step_q   <= 2'd0;
            cmd_addr <= addr;
            if (!selected)
                cmd_op <= OP_NOP;
            else if (wr_n)
                cmd_op <= OP_RD;
            else
                cmd_op <= OP_WR;
        end else begin
            step_q   <= step_inc;
            cmd_addr <= {base_q[AW-1:2], burst_low(base_q[1:0], step_inc, order_linear)};
        end
    end

endmodule

// File: rtl/pbs_lane_ram.sv
`timescale 1ns/1ps
// Storage array built as one memory per lane, so each lane has its own
// write enable. The read port is asynchronous; the caller registers it.
// Assumes DEPTH is a power of two.
module pbs_lane_ram #(
    parameter int DEPTH  = 1024,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] wr_lane,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Write this lane when the write is active and its enable is set
        always_ff @(posedge clk) begin
            if (wr_en && wr_lane[g])
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        // Lane read
        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/pbs_fwd_merge.sv
`timescale 1ns/1ps
// Lane-wise bypass: on a hit, each lane with its enable set takes the
// in-flight write data, and every other lane keeps the array value.
module pbs_fwd_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             hit,
    input  logic [LANES-1:0] lane_en,
    input  logic [DW-1:0]    new_data,
    input  logic [DW-1:0]    old_data,
    output logic [DW-1:0]    merged
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Pick the source for this lane
        always_comb begin
            if (hit && lane_en[g])
                merged[g*LANE_W +: LANE_W] = new_data[g*LANE_W +: LANE_W];
            else
                merged[g*LANE_W +: LANE_W] = old_data[g*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/pipe_burst_sram.sv
`timescale 1ns/1ps
// Pipelined burst SRAM with matched read and write latency.
// Edge n:   command sampled into the command stage.
// Edge n+1: command moves to stage two. A read samples the array, with
//           bypass from the write that commits on the same edge.
// Edge n+2: write commits with wdata/lane_wr_n sampled now; read data
//           moves to the output register.
// Assumes a power-of-two DEPTH of at least 8 words.
module pipe_burst_sram
    import pbs_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             burst_go,
    input  logic             wr_n,
    input  logic             sel_n,
    input  logic             sel_a,
    input  logic             sel_b,
    input  logic             sel_a_hi,
    input  logic             sel_b_hi,
    input  logic             order_linear,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rdata_vld
);

    op_e              c1_op;
    logic [AW-1:0]    c1_addr;
    op_e              c2_op;
    logic [AW-1:0]    c2_addr;
    logic             wr_en;
    logic [LANES-1:0] wr_lane;
    logic             fwd_hit;
    logic [DW-1:0]    arr_q;
    logic [DW-1:0]    fwd_q;
    logic [DW-1:0]    rd_q;
    logic             rd_v;

    pbs_cmd_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_go     (burst_go),
        .wr_n         (wr_n),
        .sel_n        (sel_n),
        .sel_a        (sel_a),
        .sel_b        (sel_b),
        .sel_a_hi     (sel_a_hi),
        .sel_b_hi     (sel_b_hi),
        .order_linear (order_linear),
        .addr         (addr),
        .cmd_op       (c1_op),
        .cmd_addr     (c1_addr)
    );

    // Second command stage: holds each command until its data edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2_op   <= OP_NOP;
            c2_addr <= '0;
        end else begin
            c2_op   <= c1_op;
            c2_addr <= c1_addr;
        end
    end

    // Write strobe, lane mask and bypass detection for the current edge
    always_comb begin
        wr_en   = (c2_op == OP_WR);
        wr_lane = ~lane_wr_n;
        fwd_hit = wr_en && (c2_addr == c1_addr);
    end

    pbs_lane_ram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (c2_addr),
        .wr_lane (wr_lane),
        .wr_data (wdata),
        .rd_addr (c1_addr),
        .rd_data (arr_q)
    );

    pbs_fwd_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_fwd (
        .hit      (fwd_hit),
        .lane_en  (wr_lane),
        .new_data (wdata),
        .old_data (arr_q),
        .merged   (fwd_q)
    );

    // Read stage: captures merged array data for a read in stage one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v <= 1'b0;
            rd_q <= '0;
        end else begin
            rd_v <= (c1_op == OP_RD);
            if (c1_op == OP_RD)
                rd_q <= fwd_q;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_vld <= 1'b0;
            rdata     <= '0;
        end else begin
            rdata_vld <= rd_v;
            if (rd_v)
                rdata <= rd_q;
        end
    end

endmodule

// File: rtl/pbs_checker.sv
`timescale 1ns/1ps
// Temporal checks on the pipelined burst SRAM, attached by bind.
// Relates the command stage to the output flag and the burst rules.
// Assumes the burst order is steady from a load through its advances.
module pbs_checker
    import pbs_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          burst_go,
    input logic          sel_n,
    input logic          order_linear,
    input op_e           c1_op,
    input logic [AW-1:0] c1_addr,
    input logic          rdata_vld
);

    // R2: read in stage one gives valid output two edges later
    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_op == OP_RD) |-> ##2 rdata_vld);

    // R2: write or deselect in stage one gives no valid output
    a_r2_other_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_op != OP_RD) |-> ##2 !rdata_vld);

    // R5: a load with the active-low select high is a deselect
    a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_go && sel_n) |=> (c1_op == OP_NOP));

    // R7: an advance repeats the operation
    a_r7_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go |=> (c1_op == $past(c1_op)));

    // R7: an advance keeps the upper address bits
    a_r7_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        burst_go |=> (c1_addr[AW-1:2] == $past(c1_addr[AW-1:2])));

    // R8: in linear order each advance adds one to the low bits
    a_r8_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_go && order_linear) |=>
            (c1_addr[1:0] == 2'($past(c1_addr[1:0]) + 2'd1)));

endmodule

bind pipe_burst_sram pbs_checker #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_go     (burst_go),
    .sel_n        (sel_n),
    .order_linear (order_linear),
    .c1_op        (c1_op),
    .c1_addr      (c1_addr),
    .rdata_vld    (rdata_vld)
);

// File: tb/pipe_burst_sram_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task models each command and queues the
// expected output; a monitor compares queued items as results appear.
module pipe_burst_sram_tb;
    import pbs_pkg::*;

    localparam int DEPTH  = 64;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int AW     = 6;
    localparam int DW     = 36;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [AW-1:0]    addr;
    logic             burst_go;
    logic             wr_n;
    logic             sel_n;
    logic             sel_a;
    logic             sel_b;
    logic             sel_a_hi;
    logic             sel_b_hi;
    logic             order_linear;
    logic [LANES-1:0] lane_wr_n;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    rdata;
    logic             rdata_vld;

    always #2.5 clk = ~clk;

    pipe_burst_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .burst_go(burst_go), .wr_n(wr_n),
        .sel_n(sel_n), .sel_a(sel_a), .sel_b(sel_b), .sel_a_hi(sel_a_hi),
        .sel_b_hi(sel_b_hi), .order_linear(order_linear), .lane_wr_n(lane_wr_n),
        .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    int errors = 0;
    int checks = 0;
    int edge_n = 0;
    bit done   = 0;

    always @(posedge clk) edge_n <= edge_n + 1;

    typedef struct {
        int            due;
        bit            valid;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    typedef struct {
        int               due;
        logic [DW-1:0]    data;
        logic [LANES-1:0] bwn;
    } wr_t;

    exp_t          expq[$];
    wr_t           wrq[$];
    logic [DW-1:0] model [DEPTH];
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = 2'd0;
    op_e           m_op   = OP_NOP;
    bit            lin_mode = 1'b1;
    bit            pa_hi    = 1'b1;
    bit            pb_hi    = 1'b1;

    task automatic check(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exv);
        end
    endtask

    function automatic logic [DW-1:0] pat(int a, int salt);
        return 36'(a) * 36'h0_0102_0305 + 36'h5_A5A5_0000 + 36'(salt) * 36'h1_1111_1111;
    endfunction

    // Drive one command on the next falling edge and queue its outcome
    task automatic drive(bit go, bit wrn, bit seln, bit sa, bit sb, logic [AW-1:0] a,
                         logic [DW-1:0] wd, logic [LANES-1:0] wbw, string tag);
        bit            sel;
        logic [1:0]    lo;
        logic [AW-1:0] ea;
        exp_t          e;
        wr_t           w;
        @(negedge clk);
        sel = !seln && (sa == pa_hi) && (sb == pb_hi);
        if (!go) begin
            m_base = a;
            m_step = 2'd0;
            m_op   = !sel ? OP_NOP : (wrn ? OP_RD : OP_WR);
        end else begin
            m_step = m_step + 2'd1;
        end
        lo = lin_mode ? 2'(m_base[1:0] + m_step) : (m_base[1:0] ^ m_step);
        ea = {m_base[AW-1:2], lo};
        if (m_op == OP_WR) begin
            for (int l = 0; l < LANES; l++)
                if (!wbw[l]) model[ea][l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
            w.due  = edge_n + 3;
            w.data = wd;
            w.bwn  = wbw;
            wrq.push_back(w);
        end
        e.due   = edge_n + 3;
        e.valid = (m_op == OP_RD);
        e.data  = model[ea];
        e.tag   = tag;
        expq.push_back(e);
        burst_go     = go;
        wr_n         = wrn;
        sel_n        = seln;
        sel_a        = sa;
        sel_b        = sb;
        addr         = a;
        order_linear = lin_mode;
        sel_a_hi     = pa_hi;
        sel_b_hi     = pb_hi;
        if (wrq.size() > 0 && wrq[0].due == edge_n + 1) begin
            w         = wrq.pop_front();
            wdata     = w.data;
            lane_wr_n = w.bwn;
        end else begin
            wdata     = {4'($urandom), 32'($urandom)};
            lane_wr_n = 4'($urandom);
        end
    endtask

    task automatic ld_wr(logic [AW-1:0] a, logic [DW-1:0] wd, logic [LANES-1:0] bw, string tag);
        drive(1'b0, 1'b0, 1'b0, pa_hi, pb_hi, a, wd, bw, tag);
    endtask

    task automatic ld_rd(logic [AW-1:0] a, string tag);
        drive(1'b0, 1'b1, 1'b0, pa_hi, pb_hi, a, '0, '0, tag);
    endtask

    // Advance with random values on the controls the advance must ignore
    task automatic step(logic [DW-1:0] wd, logic [LANES-1:0] bw, string tag);
        drive(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              AW'($urandom), wd, bw, tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++)
            drive(1'b0, 1'b1, 1'b1, pa_hi, pb_hi, '0, '0, '0, tag);
    endtask

    // Monitor: compare every queued item on its due edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (expq.size() > 0 && expq[0].due == edge_n) begin
                exp_t e;
                e = expq.pop_front();
                check(rdata_vld === e.valid, e.tag, "valid", 36'(rdata_vld), 36'(e.valid));
                if (e.valid)
                    check(rdata === e.data, e.tag, "data", rdata, e.data);
            end
        end
    end

    // Watchdog
    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        burst_go = 1'b0; wr_n = 1'b1; sel_n = 1'b1; sel_a = 1'b1; sel_b = 1'b1;
        sel_a_hi = 1'b1; sel_b_hi = 1'b1; order_linear = 1'b1;
        addr = '0; lane_wr_n = '1; wdata = '0;
        repeat (4) @(negedge clk);
        check(rdata_vld === 1'b0, "R1", "valid in reset", 36'(rdata_vld), 36'h0);
        rst_n = 1'b1;
        idle(3, "R1");

        // R6/R7/R8: fill memory with linear write bursts; advances ignore controls
        for (int b = 0; b < DEPTH / 4; b++) begin
            ld_wr(AW'(b * 4), pat(b * 4, 0), 4'b0000, "R6");
            for (int k = 1; k < 4; k++) step(pat(b * 4 + k, 0), 4'b0000, "R7");
        end

        // R8/R13: linear read burst from low bits 2 wraps back to start
        ld_rd(6'd6, "R2");
        step('0, '0, "R8");
        step('0, '0, "R8");
        step('0, '0, "R8");
        step('0, '0, "R13");

        // R9: interleaved order, switched on a deselect load
        lin_mode = 1'b0;
        idle(1, "R12");
        ld_rd(6'd9, "R9");
        step('0, '0, "R9");
        step('0, '0, "R9");
        step('0, '0, "R9");
        step('0, '0, "R13");
        ld_wr(6'd13, pat(13, 7), 4'b0000, "R9");
        for (int k = 1; k < 4; k++) step(pat(100 + k, 7), 4'b0000, "R9");
        ld_rd(6'd12, "R9");
        for (int k = 1; k < 4; k++) step('0, '0, "R9");
        lin_mode = 1'b1;
        idle(1, "R12");

        // R5/R12: deselect by each select input, with advances after it
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd20, pat(1, 9), 4'b0000, "R12");
        step(pat(2, 9), 4'b0000, "R12");
        step(pat(3, 9), 4'b0000, "R12");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd21, pat(4, 9), 4'b0000, "R5");
        step(pat(5, 9), 4'b0000, "R12");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd22, pat(6, 9), 4'b0000, "R5");
        idle(3, "R12");
        ld_rd(6'd20, "R12");
        ld_rd(6'd21, "R12");
        ld_rd(6'd22, "R12");
        ld_rd(6'd23, "R12");

        // R5: inverted polarities
        pa_hi = 1'b0;
        pb_hi = 1'b0;
        idle(1, "R5");
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd5, '0, '0, "R5");
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd5, '0, '0, "R5");
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd5, '0, '0, "R5");
        pa_hi = 1'b1;
        pb_hi = 1'b1;
        idle(1, "R5");

        // R3/R4: partial lane write, lanes 0 and 2 only
        ld_wr(6'd30, 36'hF_FFFF_FFFF, 4'b1010, "R4");
        idle(2, "R3");
        ld_rd(6'd30, "R4");

        // R10: alternate writes and reads every cycle
        ld_wr(6'd40, pat(40, 3), 4'b0000, "R10");
        ld_rd(6'd41, "R10");
        ld_wr(6'd42, pat(42, 3), 4'b0000, "R10");
        ld_rd(6'd43, "R10");
        ld_wr(6'd44, pat(44, 3), 4'b0000, "R10");
        ld_rd(6'd40, "R10");
        ld_rd(6'd42, "R10");

        // R11: read one and two cycles after a write to the same word
        ld_wr(6'd50, 36'h0_0000_0000, 4'b0110, "R11");
        ld_rd(6'd50, "R11");
        ld_wr(6'd51, pat(51, 5), 4'b0000, "R11");
        ld_wr(6'd44, pat(44, 6), 4'b1100, "R11");
        ld_rd(6'd51, "R11");
        ld_rd(6'd44, "R11");
        ld_wr(6'd52, pat(52, 8), 4'b0000, "R11");
        ld_rd(6'd52, "R11");
        ld_wr(6'd52, pat(52, 9), 4'b0001, "R11");
        ld_rd(6'd52, "R11");

        // R2/R3: final linear read burst over the partly written word
        ld_rd(6'd28, "R2");
        for (int k = 1; k < 4; k++) step('0, '0, "R3");
        idle(5, "R2");

        while (expq.size() > 0) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule